// File: doc/BRIEF.md
# Far Control Transfer Descriptor Checker

This block sits in a segmented protection unit and decides, for each far control transfer, which kind of transfer the referenced descriptors describe and whether their types are legal for it. A request gives the transfer kind (far CALL, far JMP, interrupt/exception delivery, or IRET back from a nested task) together with the decoded fields of the first descriptor: its selector, the system/user flag, the 4-bit type and the present flag. For gate descriptors the request also carries the selector that the gate names.

A small sequencer checks the first descriptor. A direct code segment or TSS ends the sequence. A gate makes the sequencer request the descriptor the gate points at, wait for it, and apply the rule set by the gate kind. The sequence ends in one of two ways. The first is a one-cycle completion strobe carrying the transfer class (intra-code, gate-mediated or task switch). The second is a one-cycle general-protection request carrying the selector of the descriptor that failed. The sequencer states are IDLE, CHECK_FIRST, FETCH_TARGET, CHECK_TARGET and DONE. The transitions are:
- IDLE to CHECK_FIRST on an accepted request.
- CHECK_FIRST to IDLE on a fault, to DONE for a direct target, and to FETCH_TARGET for a gate.
- FETCH_TARGET to CHECK_TARGET when the target response arrives.
- CHECK_TARGET to IDLE on a fault, otherwise to DONE.
- DONE to IDLE.

Top module: `xfer_desc_checker`

## Requirements
- R1: After reset the block is in IDLE: `req_ready`=1, and `gp_req`, `tgt_fetch` and `done_valid` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. For kind CALL (2'b00) or JMP (2'b01) whose descriptor is a code segment (`req_s`=1, `req_type` bit 3 set), `done_valid` is 1 two cycles after acceptance with `done_class`=2'b01 (intra-code). No target fetch occurs.
- R3: For CALL or JMP whose descriptor is a TSS (`req_s`=0, type 4'h9 or 4'hB), `done_valid` is 1 two cycles after acceptance with `done_class`=2'b11 (task switch).
- R4: For CALL or JMP through a call gate (`req_s`=0, type 4'hC), `tgt_fetch` is 1 from the second cycle after acceptance with `tgt_sel`=`req_gate_sel`. If the returned target is a present code segment, the sequence completes with `done_class`=2'b10 (gate-mediated).
- R5: For a task gate (`req_s`=0, type 4'h5), used by CALL, JMP or INT (2'b10), the fetched target must be a present TSS. The result is `done_class`=2'b11. Any other target raises `gp_req` with `gp_sel`=`req_gate_sel`.
- R6: For INT through an interrupt gate (type 4'hE) or trap gate (type 4'hF), with `req_s`=0, the fetched target must be a present code segment. The result is `done_class`=2'b10.
- R7: When a call, interrupt or trap gate points at anything other than a code segment, `gp_req` is 1 in the cycle after the target response, with `gp_sel`=`req_gate_sel`.
- R8: For IRET (2'b11), the descriptor named by the previous-task link must be a present TSS. On success the result is `done_class`=2'b11 with no fetch. Otherwise `gp_req` is raised with `gp_sel`=`req_sel`.
- R9: A first descriptor whose type the transfer kind does not allow raises `gp_req` in the cycle after acceptance, with `gp_sel`=`req_sel`, and no fetch occurs. Disallowed first descriptors include data segments, reserved or other system types, interrupt/trap gates for CALL/JMP, and code segments or TSSs for INT.
- R10: A descriptor with its present flag at 0, at either stage, raises `gp_req` with that descriptor's selector.
- R11: In FETCH_TARGET the block holds `tgt_fetch` and `tgt_sel` for as many cycles as `tgt_rsp_valid` stays 0. A `tgt_rsp_valid` pulse outside FETCH_TARGET leaves the block in IDLE.
- R12: `gp_req` and `done_valid` are one-cycle pulses and are never 1 together. The block returns to IDLE (`req_ready`=1) in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request strobe |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_kind | input | 2 | 00 CALL, 01 JMP, 10 INT, 11 IRET |
| req_sel | input | SEL_W | Selector of the first descriptor |
| req_s | input | 1 | First descriptor: 1 = code/data, 0 = system |
| req_type | input | 4 | First descriptor type field |
| req_present | input | 1 | First descriptor present flag |
| req_gate_sel | input | SEL_W | Selector named by the gate |
| tgt_fetch | output | 1 | Request for the gate's target descriptor |
| tgt_sel | output | SEL_W | Selector to fetch |
| tgt_rsp_valid | input | 1 | Target descriptor fields are valid |
| tgt_rsp_s | input | 1 | Target system/user flag |
| tgt_rsp_type | input | 4 | Target type field |
| tgt_rsp_present | input | 1 | Target present flag |
| done_valid | output | 1 | Successful completion strobe |
| done_class | output | 2 | 01 intra-code, 10 gate-mediated, 11 task switch |
| gp_req | output | 1 | General-protection request strobe |
| gp_sel | output | SEL_W | Selector of the failing descriptor |

## Verification
The hardest case to reach is a second-stage failure after a long wait. The gate must pass its own check and the sequencer must sit in FETCH_TARGET for several cycles. Then a bad or absent target must arrive, and the fault selector must switch from the request selector to the gate's target selector. The bench reaches this with scripted transfers that hold back `tgt_rsp_valid` for a chosen number of cycles before returning a wrong target type. A behavioural model compares every output on every clock. Stray target responses are also driven while the block is idle.

// File: rtl/xfer_chk_pkg.sv
package xfer_chk_pkg;

    localparam int DTYPE_W = 4;

    typedef enum logic [1:0] {
        K_CALL = 2'b00,
        K_JMP  = 2'b01,
        K_INT  = 2'b10,
        K_IRET = 2'b11
    } xfer_kind_e;

    typedef enum logic [2:0] {
        D_CODE,
        D_DATA,
        D_TSS,
        D_CALLG,
        D_TASKG,
        D_INTG,
        D_TRAPG,
        D_OTHER
    } desc_cat_e;

    typedef enum logic [1:0] {
        C_NONE  = 2'b00,
        C_INTRA = 2'b01,
        C_GATE  = 2'b10,
        C_TASK  = 2'b11
    } xfer_class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK_FIRST,
        ST_FETCH_TARGET,
        ST_CHECK_TARGET,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/desc_classify.sv
module desc_classify
    import xfer_chk_pkg::*;
(
    input  logic               s_flag,
    input  logic [DTYPE_W-1:0] dtype,
    output desc_cat_e          cat
);
    always_comb begin
        if (s_flag) begin
            cat = dtype[3] ? D_CODE : D_DATA;
        end else begin
            unique case (dtype)
                4'h9, 4'hB: cat = D_TSS;
                4'hC:       cat = D_CALLG;
                4'h5:       cat = D_TASKG;
                4'hE:       cat = D_INTG;
                4'hF:       cat = D_TRAPG;
                default:    cat = D_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/first_stage_rule.sv
module first_stage_rule
    import xfer_chk_pkg::*;
(
    input  xfer_kind_e  kind,
    input  desc_cat_e   cat,
    input  logic        present,
    output logic        fault,
    output logic        need_target,
    output logic        want_code,
    output xfer_class_e cls
);
    logic legal;

    always_comb begin
        legal       = 1'b0;
        need_target = 1'b0;
        want_code   = 1'b0;
        cls         = C_NONE;
        unique case (kind)
            K_CALL, K_JMP: begin
                unique case (cat)
                    D_CODE:  begin legal = 1'b1; cls = C_INTRA; end
                    D_TSS:   begin legal = 1'b1; cls = C_TASK;  end
                    D_CALLG: begin legal = 1'b1; cls = C_GATE; need_target = 1'b1; want_code = 1'b1; end
                    D_TASKG: begin legal = 1'b1; cls = C_TASK; need_target = 1'b1; end
                    default: legal = 1'b0;
                endcase
            end
            K_INT: begin
                unique case (cat)
                    D_INTG, D_TRAPG: begin legal = 1'b1; cls = C_GATE; need_target = 1'b1; want_code = 1'b1; end
                    D_TASKG:         begin legal = 1'b1; cls = C_TASK; need_target = 1'b1; end
                    default:         legal = 1'b0;
                endcase
            end
            K_IRET: begin
                if (cat == D_TSS) begin
                    legal = 1'b1;
                    cls   = C_TASK;
                end
            end
            default: legal = 1'b0;
        endcase
        fault = !(legal && present);
    end
endmodule

// File: rtl/xfer_desc_checker.sv
module xfer_desc_checker
    import xfer_chk_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_kind,
    input  logic [SEL_W-1:0]   req_sel,
    input  logic               req_s,
    input  logic [DTYPE_W-1:0] req_type,
    input  logic               req_present,
    input  logic [SEL_W-1:0]   req_gate_sel,
    output logic               tgt_fetch,
    output logic [SEL_W-1:0]   tgt_sel,
    input  logic               tgt_rsp_valid,
    input  logic               tgt_rsp_s,
    input  logic [DTYPE_W-1:0] tgt_rsp_type,
    input  logic               tgt_rsp_present,
    output logic               done_valid,
    output logic [1:0]         done_class,
    output logic               gp_req,
    output logic [SEL_W-1:0]   gp_sel
);
    seq_state_e         state_q, state_d;
    xfer_kind_e         kind_q;
    logic [SEL_W-1:0]   sel_q, gsel_q;
    logic               s_q, p_q, ts_q, tp_q;
    logic [DTYPE_W-1:0] type_q, ttype_q;

    desc_cat_e   cat_first, cat_tgt;
    logic        fault_first, need_tgt, want_code;
    xfer_class_e cls_first;
    logic        tgt_ok;

    desc_classify u_cls_first (.s_flag(s_q),  .dtype(type_q),  .cat(cat_first));
    desc_classify u_cls_tgt   (.s_flag(ts_q), .dtype(ttype_q), .cat(cat_tgt));

    first_stage_rule u_rule (
        .kind        (kind_q),
        .cat         (cat_first),
        .present     (p_q),
        .fault       (fault_first),
        .need_target (need_tgt),
        .want_code   (want_code),
        .cls         (cls_first)
    );

    assign tgt_ok = tp_q && (want_code ? (cat_tgt == D_CODE) : (cat_tgt == D_TSS));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured descriptor fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_CALL;
            sel_q   <= '0;
            gsel_q  <= '0;
            s_q     <= 1'b0;
            type_q  <= '0;
            p_q     <= 1'b0;
            ts_q    <= 1'b0;
            ttype_q <= '0;
            tp_q    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                kind_q <= xfer_kind_e'(req_kind);
                sel_q  <= req_sel;
                gsel_q <= req_gate_sel;
                s_q    <= req_s;
                type_q <= req_type;
                p_q    <= req_present;
            end
            if (state_q == ST_FETCH_TARGET && tgt_rsp_valid) begin
                ts_q    <= tgt_rsp_s;
                ttype_q <= tgt_rsp_type;
                tp_q    <= tgt_rsp_present;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:         if (req_valid) state_d = ST_CHECK_FIRST;
            ST_CHECK_FIRST:  state_d = fault_first ? ST_IDLE
                                     : (need_tgt ? ST_FETCH_TARGET : ST_DONE);
            ST_FETCH_TARGET: if (tgt_rsp_valid) state_d = ST_CHECK_TARGET;
            ST_CHECK_TARGET: state_d = tgt_ok ? ST_DONE : ST_IDLE;
            ST_DONE:         state_d = ST_IDLE;
            default:         state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        tgt_fetch  = 1'b0;
        tgt_sel    = gsel_q;
        gp_req     = 1'b0;
        gp_sel     = '0;
        done_valid = 1'b0;
        done_class = C_NONE;
        unique case (state_q)
            ST_IDLE:         req_ready = 1'b1;
            ST_CHECK_FIRST:  begin gp_req = fault_first; gp_sel = fault_first ? sel_q : '0; end
            ST_FETCH_TARGET: tgt_fetch = 1'b1;
            ST_CHECK_TARGET: begin gp_req = !tgt_ok; gp_sel = tgt_ok ? '0 : gsel_q; end
            ST_DONE:         begin done_valid = 1'b1; done_class = cls_first; end
            default:         req_ready = 1'b0;
        endcase
    end

    // R1: accepted request leaves IDLE
    p_accept_leaves_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

    // R2: completion always carries a real class
    p_done_has_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_class != C_NONE));

    // R10: absent target leads to a fault on its selector
    p_absent_target_gp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_fetch && tgt_rsp_valid && !tgt_rsp_present) |=> (gp_req && gp_sel == $past(tgt_sel)));

    // R11: fetch request held while waiting
    p_fetch_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_fetch && !tgt_rsp_valid) |=> (tgt_fetch && $stable(tgt_sel)));

    // R12: pulses and mutual exclusion
    p_gp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        gp_req |=> (!gp_req && req_ready));
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && req_ready));
    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(gp_req && done_valid));
endmodule

// File: tb/xfer_desc_checker_tb_top.sv
module xfer_desc_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_sel = '0;
    logic        req_s = 1'b0;
    logic [3:0]  req_type = '0;
    logic        req_present = 1'b0;
    logic [15:0] req_gate_sel = '0;
    logic        tgt_fetch;
    logic [15:0] tgt_sel;
    logic        tgt_rsp_valid = 1'b0;
    logic        tgt_rsp_s = 1'b0;
    logic [3:0]  tgt_rsp_type = '0;
    logic        tgt_rsp_present = 1'b0;
    logic        done_valid;
    logic [1:0]  done_class;
    logic        gp_req;
    logic [15:0] gp_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xfer_desc_checker #(.SEL_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_sel(req_sel), .req_s(req_s), .req_type(req_type),
        .req_present(req_present), .req_gate_sel(req_gate_sel),
        .tgt_fetch(tgt_fetch), .tgt_sel(tgt_sel),
        .tgt_rsp_valid(tgt_rsp_valid), .tgt_rsp_s(tgt_rsp_s),
        .tgt_rsp_type(tgt_rsp_type), .tgt_rsp_present(tgt_rsp_present),
        .done_valid(done_valid), .done_class(done_class),
        .gp_req(gp_req), .gp_sel(gp_sel)
    );

    task automatic chk(string rq, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    // compare every output in the current cycle
    task automatic cyc(string rq, bit e_rdy, bit e_gp, int e_gsel,
                       bit e_fetch, int e_fsel, bit e_done, int e_cls);
        chk(rq, "req_ready", req_ready, e_rdy);
        chk(rq, "gp_req", gp_req, e_gp);
        if (e_gp) chk(rq, "gp_sel", gp_sel, e_gsel);
        chk(rq, "tgt_fetch", tgt_fetch, e_fetch);
        if (e_fetch) chk(rq, "tgt_sel", tgt_sel, e_fsel);
        chk(rq, "done_valid", done_valid, e_done);
        if (e_done) chk(rq, "done_class", done_class, e_cls);
    endtask

    function automatic bit is_code(bit s, bit [3:0] t);
        return s && t[3];
    endfunction

    function automatic bit is_tss(bit s, bit [3:0] t);
        return !s && (t == 4'h9 || t == 4'hB);
    endfunction

    // behavioural model of the first-stage decision
    task automatic model_first(int kind, bit s, bit [3:0] t, bit p,
                               output bit fault, output bit need,
                               output bit wcode, output int cls);
        bit ok = 0;
        need = 0; wcode = 0; cls = 0;
        if (kind == 0 || kind == 1) begin
            if (is_code(s, t))              begin ok = 1; cls = 1; end
            else if (is_tss(s, t))          begin ok = 1; cls = 3; end
            else if (!s && t == 4'hC)       begin ok = 1; cls = 2; need = 1; wcode = 1; end
            else if (!s && t == 4'h5)       begin ok = 1; cls = 3; need = 1; end
        end else if (kind == 2) begin
            if (!s && (t == 4'hE || t == 4'hF)) begin ok = 1; cls = 2; need = 1; wcode = 1; end
            else if (!s && t == 4'h5)           begin ok = 1; cls = 3; need = 1; end
        end else begin
            if (is_tss(s, t)) begin ok = 1; cls = 3; end
        end
        fault = !(ok && p);
    endtask

    task automatic run(string rq, int kind, bit [15:0] sel, bit s, bit [3:0] t, bit p,
                       bit [15:0] gsel, int waitc, bit ts, bit [3:0] tt, bit tp);
        bit fault, need, wcode, tok;
        int cls;
        model_first(kind, s, t, p, fault, need, wcode, cls);
        @(negedge clk);
        cyc(rq, 1, 0, 0, 0, 0, 0, 0);
        req_valid = 1; req_kind = kind[1:0]; req_sel = sel; req_s = s;
        req_type = t; req_present = p; req_gate_sel = gsel;
        @(negedge clk);
        req_valid = 0;
        cyc(rq, 0, fault, sel, 0, 0, 0, 0);
        if (fault) begin
            @(negedge clk); cyc(rq, 1, 0, 0, 0, 0, 0, 0);
            return;
        end
        if (!need) begin
            @(negedge clk); cyc(rq, 0, 0, 0, 0, 0, 1, cls);
            @(negedge clk); cyc(rq, 1, 0, 0, 0, 0, 0, 0);
            return;
        end
        for (int i = 0; i <= waitc; i++) begin
            @(negedge clk);
            cyc(rq, 0, 0, 0, 1, gsel, 0, 0);
            tgt_rsp_valid = (i == waitc);
            tgt_rsp_s = ts; tgt_rsp_type = tt; tgt_rsp_present = tp;
        end
        tok = tp && (wcode ? is_code(ts, tt) : is_tss(ts, tt));
        @(negedge clk);
        tgt_rsp_valid = 0;
        cyc(rq, 0, !tok, gsel, 0, 0, 0, 0);
        if (tok) begin
            @(negedge clk); cyc(rq, 0, 0, 0, 0, 0, 1, cls);
        end
        @(negedge clk); cyc(rq, 1, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cyc("R1", 1, 0, 0, 0, 0, 0, 0);
        rst_n = 1;

        // R2 direct code
        run("R2", 0, 16'h0010, 1, 4'hA, 1, 16'h0, 0, 0, 0, 0);
        run("R2", 1, 16'h0018, 1, 4'h8, 1, 16'h0, 0, 0, 0, 0);
        // R3 direct TSS
        run("R3", 1, 16'h0020, 0, 4'h9, 1, 16'h0, 0, 0, 0, 0);
        run("R3", 0, 16'h0028, 0, 4'hB, 1, 16'h0, 0, 0, 0, 0);
        // R4 call gate
        run("R4", 0, 16'h0030, 0, 4'hC, 1, 16'h0138, 0, 1, 4'hA, 1);
        run("R4", 1, 16'h0040, 0, 4'hC, 1, 16'h0148, 3, 1, 4'hE, 1);
        // R5 task gate
        run("R5", 1, 16'h0050, 0, 4'h5, 1, 16'h0250, 0, 0, 4'hB, 1);
        run("R5", 0, 16'h0058, 0, 4'h5, 1, 16'h0258, 1, 1, 4'hA, 1);
        run("R5", 2, 16'h0060, 0, 4'h5, 1, 16'h0260, 2, 0, 4'h9, 1);
        // R6 interrupt and trap gates
        run("R6", 2, 16'h0070, 0, 4'hE, 1, 16'h0370, 0, 1, 4'h8, 1);
        run("R6", 2, 16'h0078, 0, 4'hF, 1, 16'h0378, 2, 1, 4'hB, 1);
        // R7 gate target not code
        run("R7", 0, 16'h0080, 0, 4'hC, 1, 16'h0480, 1, 1, 4'h2, 1);
        run("R7", 2, 16'h0088, 0, 4'hF, 1, 16'h0488, 4, 0, 4'h9, 1);
        run("R7", 2, 16'h008C, 0, 4'hE, 1, 16'h048C, 0, 0, 4'hC, 1);
        // R8 IRET link
        run("R8", 3, 16'h0090, 0, 4'hB, 1, 16'h0, 0, 0, 0, 0);
        run("R8", 3, 16'h0098, 1, 4'hA, 1, 16'h0, 0, 0, 0, 0);
        run("R8", 3, 16'h009C, 0, 4'h5, 1, 16'h0, 0, 0, 0, 0);
        // R9 disallowed first descriptors
        run("R9", 0, 16'h00A0, 1, 4'h3, 1, 16'h05A0, 0, 0, 0, 0);
        run("R9", 1, 16'h00A8, 0, 4'h2, 1, 16'h05A8, 0, 0, 0, 0);
        run("R9", 0, 16'h00B0, 0, 4'hE, 1, 16'h05B0, 0, 0, 0, 0);
        run("R9", 2, 16'h00B8, 1, 4'hA, 1, 16'h05B8, 0, 0, 0, 0);
        run("R9", 1, 16'h00C0, 0, 4'h8, 1, 16'h05C0, 0, 0, 0, 0);
        run("R9", 2, 16'h00C4, 0, 4'h9, 1, 16'h05C4, 0, 0, 0, 0);
        // R10 not present
        run("R10", 0, 16'h00D0, 1, 4'hA, 0, 16'h0, 0, 0, 0, 0);
        run("R10", 0, 16'h00D8, 0, 4'hC, 1, 16'h06D8, 1, 1, 4'hA, 0);
        run("R10", 3, 16'h00DC, 0, 4'h9, 0, 16'h0, 0, 0, 0, 0);
        // R11 stray response while idle, then a long wait
        @(negedge clk);
        tgt_rsp_valid = 1; tgt_rsp_s = 1; tgt_rsp_type = 4'hA; tgt_rsp_present = 1;
        @(negedge clk);
        tgt_rsp_valid = 0;
        cyc("R11", 1, 0, 0, 0, 0, 0, 0);
        run("R11", 1, 16'h00E0, 0, 4'hC, 1, 16'h07E0, 20, 1, 4'hF, 1);
        // R12 back-to-back: fault then success
        run("R12", 0, 16'h00F0, 0, 4'h0, 1, 16'h0, 0, 0, 0, 0);
        run("R12", 1, 16'h00F8, 1, 4'hC, 1, 16'h0, 0, 0, 0, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule